// File: doc/BRIEF.md
# PIO Transmit Frame Loader

This block lets a processor stage an outgoing frame by programmed I/O. Software picks a transmit channel and writes the frame as 32-bit words to one data register. Each write lands in that channel's word FIFO. Software then writes the byte length of the frame and sets a start bit. The block then unpacks the buffered words and sends the frame out as a byte stream with a valid/ready/last handshake. A status register shows the busy state, the end of the frame, an overflow flag and the fill level of the selected channel's FIFO.

Each channel has its own FIFO. Only the selected channel accepts words, and a start sends the selected channel. Bytes leave the least significant byte of each word first. Pad bytes after the programmed length are not sent. When a frame ends, the FIFO of the channel that sent it is emptied, so the next frame starts clean. The feed-mode bit selects processor feeding (value 0), which is the only feeding this block carries out. Value 1 stands for the externally fed mode, which this block does not implement, so while it is 1 the data port and the start bit do nothing.

Register word addresses on `reg_addr`:
- 0: feed mode, bit 0.
- 1: channel select, low bits.
- 2: data port, write only.
- 3: byte length of the selected channel, bits 15:0.
- 4: control. Bit 0 written as 1 requests a start; read back, bit 0 is 1 while a frame is being sent.
- 5: status. Bit 0 is busy, bit 1 is the overflow flag (writing 1 to bit 1 clears it), bit 2 is done, and bits 15:8 hold the word count of the selected channel's FIFO.

Top module: `pio_tx_loader`

## Requirements
- R1: After reset, `tx_valid` and `tx_last` are 0, the status register reads 0 and the channel select reads 0.
- R2: Bytes are sent in the order the words were written, and within each word from bits 7:0 up to bits 31:24.
- R3: A frame sends exactly the programmed number of bytes. `tx_last` is 1 on the final byte and on no other byte. Pad bytes in the last word are never sent, and `tx_valid` is 0 in the cycle after the last byte is accepted.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_last` stay unchanged into the next cycle.
- R5: Status bit 0 and control bit 0 read 1 from the accepted start until the last byte has been accepted, and 0 after that. Status bit 2 (done) is set when a frame ends and is cleared by the next accepted start.
- R6: A data-port write while busy, or while the selected FIFO already holds its full depth, does not change any FIFO and sets status bit 1 (overflow). Writing 1 to status bit 1 clears the flag.
- R7: Data-port writes fill only the FIFO of the currently selected channel. A start sends that channel and leaves the other channels' FIFOs unchanged.
- R8: A start request is ignored (busy stays 0 and no byte is sent) when the length is 0, when the length is more than 4 times the selected FIFO's word count, when the feed mode is 1, or when busy.
- R9: While the feed mode is 1, data-port writes leave the FIFO level unchanged and do not set the overflow flag.
- R10: When a frame ends, the transmitting channel's FIFO reads a word count of 0, including any words written beyond the programmed length.
- R11: Status bits 15:8 report the number of words held in the selected channel's FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 3 | Register word address, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | `tx_data` holds a byte |
| tx_last | output | 1 | The current byte is the last byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |

## Verification
Frames are sent with lengths of 1, 5, 7, 8, 16 and 64 bytes:
- Lengths that are not a multiple of four show whether pad bytes are dropped and where `tx_last` lands.
- A frame staged with more words than its length needs shows whether the leftover words are flushed.
- A frame that fills the FIFO to its full depth tests the depth boundary and the overflow on the next write.

The downstream ready is driven both always high and in a repeating stall pattern. This separates correct byte holding from bytes that advance without a handshake. Two channels are loaded with different contents before a send, which shows whether the channel select routes both the writes and the start. Start requests that should be refused (zero length, too few words, feed mode 1) are checked against busy and the output.

// File: rtl/txl_pkg.sv
package txl_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_MODE   = 3'd0,
        REG_CHSEL  = 3'd1,
        REG_DATA   = 3'd2,
        REG_LEN    = 3'd3,
        REG_CTRL   = 3'd4,
        REG_STATUS = 3'd5
    } reg_sel_e;

    localparam int ST_BUSY    = 0;
    localparam int ST_OVF     = 1;
    localparam int ST_DONE    = 2;
    localparam int ST_LVL_LSB = 8;

endpackage

// File: rtl/txl_word_fifo.sv
module txl_word_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [CNT_W-1:0]  level,
    output logic              full
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WORD_W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[st_q.wp] <= push_data;
        end
    end

    assign head  = mem[st_q.rp];
    assign level = st_q.cnt;
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/txl_byte_unpack.sv
module txl_byte_unpack #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16,
    localparam int BPW   = WORD_W / 8,
    localparam int IDX_W = (BPW > 1) ? $clog2(BPW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [WORD_W-1:0] word_in,
    output logic              pop,
    output logic              sending,
    output logic              frame_done,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready
);

    typedef struct packed {
        logic              active;
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  rem;
    } unpack_st_t;

    unpack_st_t st_d, st_q;
    logic fire;

    always_comb begin
        st_d       = st_q;
        pop        = 1'b0;
        frame_done = 1'b0;
        fire       = st_q.active && tx_ready;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.word   = word_in;
                st_d.idx    = '0;
                st_d.rem    = start_len;
                pop         = 1'b1;
            end
        end else if (fire) begin
            if (st_q.rem == LEN_W'(1)) begin
                st_d.active = 1'b0;
                frame_done  = 1'b1;
            end else begin
                st_d.rem = st_q.rem - 1'b1;
                if (st_q.idx == IDX_W'(BPW - 1)) begin
                    st_d.word = word_in;
                    st_d.idx  = '0;
                    pop       = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_data  = st_q.word[{st_q.idx, 3'b000} +: 8];
    assign tx_valid = st_q.active;
    assign tx_last  = st_q.active && (st_q.rem == LEN_W'(1));
    assign sending  = st_q.active;

endmodule

// File: rtl/txl_regs.sv
module txl_regs
    import txl_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 5,
    parameter int WORD_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BPW   = WORD_W / 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_ADDR_W-1:0]        addr,
    input  logic [31:0]                  wdata,
    output logic [31:0]                  rdata,
    input  logic [NUM_CH-1:0][CNT_W-1:0] fifo_level,
    input  logic [NUM_CH-1:0]            fifo_full,
    input  logic                         sending,
    input  logic                         frame_done,
    output logic [NUM_CH-1:0]            push,
    output logic [NUM_CH-1:0]            clr,
    output logic                         start,
    output logic [LEN_W-1:0]             start_len,
    output logic [CH_W-1:0]              rd_ch,
    output logic                         ovf_flag,
    output logic                         done_flag
);

    typedef struct packed {
        logic                         feed_ext;
        logic [CH_W-1:0]              chsel;
        logic [CH_W-1:0]              act_ch;
        logic                         ovf;
        logic                         done;
        logic [NUM_CH-1:0][LEN_W-1:0] len;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic [CH_W-1:0] sel;
    logic [31:0]     cap_bytes;
    logic            len_ok;

    always_comb begin
        sel       = st_q.chsel;
        cap_bytes = 32'(fifo_level[sel]) * 32'(BPW);
        len_ok    = (st_q.len[sel] != '0) && (32'(st_q.len[sel]) <= cap_bytes);
        st_d      = st_q;
        push      = '0;
        clr       = '0;
        start     = 1'b0;
        if (wr_en) begin
            case (addr)
                REG_MODE:  st_d.feed_ext = wdata[0];
                REG_CHSEL: begin
                    if (32'(wdata[CH_W-1:0]) < 32'(NUM_CH)) begin
                        st_d.chsel = wdata[CH_W-1:0];
                    end
                end
                REG_DATA: begin
                    if (sending || (!st_q.feed_ext && fifo_full[sel])) begin
                        st_d.ovf = 1'b1;
                    end else if (!st_q.feed_ext) begin
                        push[sel] = 1'b1;
                    end
                end
                REG_LEN:  st_d.len[sel] = wdata[LEN_W-1:0];
                REG_CTRL: begin
                    if (wdata[0] && !sending && !st_q.feed_ext && len_ok) begin
                        start       = 1'b1;
                        st_d.act_ch = sel;
                        st_d.done   = 1'b0;
                    end
                end
                REG_STATUS: begin
                    if (wdata[ST_OVF]) begin
                        st_d.ovf = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (frame_done) begin
            st_d.done         = 1'b1;
            clr[st_q.act_ch]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_MODE:   rdata[0] = st_q.feed_ext;
            REG_CHSEL:  rdata[CH_W-1:0] = st_q.chsel;
            REG_LEN:    rdata[LEN_W-1:0] = st_q.len[sel];
            REG_CTRL:   rdata[0] = sending;
            REG_STATUS: begin
                rdata[ST_BUSY]                 = sending;
                rdata[ST_OVF]                  = st_q.ovf;
                rdata[ST_DONE]                 = st_q.done;
                rdata[ST_LVL_LSB +: CNT_W]     = fifo_level[sel];
            end
            default: rdata = '0;
        endcase
    end

    assign start_len = st_q.len[sel];
    assign rd_ch     = start ? sel : st_q.act_ch;
    assign ovf_flag  = st_q.ovf;
    assign done_flag = st_q.done;

endmodule

// File: rtl/pio_tx_loader.sv
module pio_tx_loader
    import txl_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int FIFO_DEPTH = 16,
    parameter int LEN_W      = 16,
    localparam int WORD_W    = 32,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic [7:0]            tx_data,
    output logic                  tx_valid,
    output logic                  tx_last,
    input  logic                  tx_ready
);

    logic [NUM_CH-1:0][CNT_W-1:0]  level_w;
    logic [NUM_CH-1:0]             full_w;
    logic [NUM_CH-1:0][WORD_W-1:0] head_w;
    logic [NUM_CH-1:0]             push_w;
    logic [NUM_CH-1:0]             clr_w;
    logic                          start_w;
    logic [LEN_W-1:0]              start_len_w;
    logic [CH_W-1:0]               rd_ch_w;
    logic                          pop_w;
    logic                          sending_w;
    logic                          frame_done_w;
    logic                          ovf_flag_w;
    logic                          done_flag_w;

    txl_regs #(
        .NUM_CH (NUM_CH),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W),
        .WORD_W (WORD_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .fifo_level (level_w),
        .fifo_full  (full_w),
        .sending    (sending_w),
        .frame_done (frame_done_w),
        .push       (push_w),
        .clr        (clr_w),
        .start      (start_w),
        .start_len  (start_len_w),
        .rd_ch      (rd_ch_w),
        .ovf_flag   (ovf_flag_w),
        .done_flag  (done_flag_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        txl_word_fifo #(
            .WORD_W (WORD_W),
            .DEPTH  (FIFO_DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr_w[c]),
            .push      (push_w[c]),
            .push_data (reg_wdata),
            .pop       (pop_w && (rd_ch_w == CH_W'(c))),
            .head      (head_w[c]),
            .level     (level_w[c]),
            .full      (full_w[c])
        );
    end

    txl_byte_unpack #(
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .start_len  (start_len_w),
        .word_in    (head_w[rd_ch_w]),
        .pop        (pop_w),
        .sending    (sending_w),
        .frame_done (frame_done_w),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready)
    );

endmodule

// File: rtl/txl_checker.sv
module txl_checker
    import txl_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr_en,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [7:0]            tx_data,
    input logic                  tx_valid,
    input logic                  tx_last,
    input logic                  tx_ready,
    input logic                  sending,
    input logic                  frame_done,
    input logic                  done_flag,
    input logic                  ovf_flag
);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R3

    AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !tx_valid); // R3

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> done_flag && !sending); // R5

    AST_BUSY_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && (reg_addr == REG_DATA) && sending |=> ovf_flag); // R6

endmodule

bind pio_tx_loader txl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready),
    .sending    (sending_w),
    .frame_done (frame_done_w),
    .done_flag  (done_flag_w),
    .ovf_flag   (ovf_flag_w)
);

// File: tb/pio_tx_loader_tb.sv
module pio_tx_loader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int A_MODE = 0, A_CHSEL = 1, A_DATA = 2, A_LEN = 3, A_CTRL = 4, A_STATUS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    int rmode = 0;
    int cyc = 0;
    int rx_n = 0;
    logic [7:0] rx_b [256];
    logic       rx_l [256];
    int stall_bad = 0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic [7:0] prev_last = '0;
    bit   done_run = 0;

    pio_tx_loader u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always begin
        @(posedge clk);
        #1;
        cyc++;
        tx_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
    end

    always @(negedge clk) begin
        if (prev_stall && (tx_data != prev_data || 8'(tx_last) != prev_last)) stall_bad++;
        prev_stall = tx_valid && !tx_ready;
        prev_data  = tx_data;
        prev_last  = 8'(tx_last);
        if (tx_valid && tx_ready && rx_n < 256) begin
            rx_b[rx_n] = tx_data;
            rx_l[rx_n] = tx_last;
            rx_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk);
        #1;
        reg_wr_en = 1'b1;
        reg_addr  = 3'(a);
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(posedge clk);
        #1;
        reg_addr = 3'(a);
        @(negedge clk);
        d = reg_rdata;
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed + 7 * k);
    endfunction

    task automatic load_words(input int nwords, input int seed);
        for (int i = 0; i < nwords; i++) begin
            wr(A_DATA, {pat(seed, 4*i+3), pat(seed, 4*i+2), pat(seed, 4*i+1), pat(seed, 4*i)});
        end
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 1000; i++) begin
            rd(A_STATUS, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic check_rx(input int nbytes, input int seed, input string tag);
        int bad_b = 0;
        int bad_l = 0;
        chk(rx_n == nbytes, "R3", {tag, " byte count"}, rx_n, nbytes);
        for (int k = 0; k < rx_n && k < nbytes; k++) begin
            if (rx_b[k] != pat(seed, k)) bad_b++;
            if (rx_l[k] != (k == nbytes - 1)) bad_l++;
        end
        chk(bad_b == 0, "R2", {tag, " byte order mismatches"}, bad_b, 0);
        chk(bad_l == 0, "R3", {tag, " last marker mismatches"}, bad_l, 0);
        chk(stall_bad == 0, "R4", {tag, " data changed during stall"}, stall_bad, 0);
    endtask

    task automatic send_frame(input int nbytes, input int seed, input int mode, input string tag);
        logic [31:0] s;
        logic [31:0] c;
        rmode = mode;
        stall_bad = 0;
        wr(A_LEN, 32'(nbytes));
        rx_n = 0;
        wr(A_CTRL, 32'd1);
        if (nbytes >= 4) begin
            rd(A_STATUS, s);
            chk(s[0] == 1'b1, "R5", {tag, " busy after start"}, int'(s[0]), 1);
            chk(s[2] == 1'b0, "R5", {tag, " done cleared by start"}, int'(s[2]), 0);
            rd(A_CTRL, c);
            chk(c[0] == 1'b1, "R5", {tag, " start bit held"}, int'(c[0]), 1);
        end
        wait_idle();
        rd(A_STATUS, s);
        chk(s[0] == 1'b0, "R5", {tag, " busy clear at end"}, int'(s[0]), 0);
        chk(s[2] == 1'b1, "R5", {tag, " done set"}, int'(s[2]), 1);
        chk(s[15:8] == 8'd0, "R10", {tag, " fifo flushed"}, int'(s[15:8]), 0);
        check_rx(nbytes, seed, tag);
        rmode = 0;
    endtask

    task automatic t_reset();
        logic [31:0] s;
        chk(tx_valid == 1'b0, "R1", "tx_valid after reset", int'(tx_valid), 0);
        chk(tx_last == 1'b0, "R1", "tx_last after reset", int'(tx_last), 0);
        rd(A_STATUS, s);
        chk(s == 32'd0, "R1", "status after reset", int'(s), 0);
        rd(A_CHSEL, s);
        chk(s == 32'd0, "R1", "channel after reset", int'(s), 0);
    endtask

    task automatic t_frame(input int ch, input int nwords, input int nbytes, input int seed, input int mode, input string tag);
        logic [31:0] s;
        wr(A_CHSEL, 32'(ch));
        load_words(nwords, seed);
        rd(A_STATUS, s);
        chk(s[15:8] == 8'(nwords), "R11", {tag, " level"}, int'(s[15:8]), nwords);
        send_frame(nbytes, seed, mode, tag);
    endtask

    task automatic t_channels();
        logic [31:0] s;
        wr(A_CHSEL, 32'd1);
        load_words(2, 8'h21);
        wr(A_CHSEL, 32'd0);
        load_words(1, 8'h90);
        rd(A_STATUS, s);
        chk(s[15:8] == 8'd1, "R7", "ch0 level", int'(s[15:8]), 1);
        wr(A_CHSEL, 32'd1);
        rd(A_STATUS, s);
        chk(s[15:8] == 8'd2, "R7", "ch1 level", int'(s[15:8]), 2);
        send_frame(8, 8'h21, 1, "R7 ch1");
        wr(A_CHSEL, 32'd0);
        rd(A_STATUS, s);
        chk(s[15:8] == 8'd1, "R7", "ch0 untouched by ch1 send", int'(s[15:8]), 1);
        send_frame(4, 8'h90, 0, "R7 ch0");
    endtask

    task automatic t_busy_write();
        logic [31:0] s;
        wr(A_CHSEL, 32'd0);
        load_words(4, 8'h33);
        rmode = 1;
        wr(A_LEN, 32'd16);
        rx_n = 0;
        stall_bad = 0;
        wr(A_CTRL, 32'd1);
        wr(A_DATA, 32'hDEADBEEF);
        rd(A_STATUS, s);
        chk(s[1] == 1'b1, "R6", "overflow after busy write", int'(s[1]), 1);
        wait_idle();
        rd(A_STATUS, s);
        chk(s[15:8] == 8'd0, "R6", "busy write not stored", int'(s[15:8]), 0);
        check_rx(16, 8'h33, "R6 busy");
        rmode = 0;
        wr(A_STATUS, 32'd2);
        rd(A_STATUS, s);
        chk(s[1] == 1'b0, "R6", "overflow cleared", int'(s[1]), 0);
    endtask

    task automatic t_full();
        logic [31:0] s;
        wr(A_CHSEL, 32'd0);
        load_words(16, 8'h05);
        rd(A_STATUS, s);
        chk(s[15:8] == 8'd16 && s[1] == 1'b0, "R11", "full level no flag", int'(s[15:8]), 16);
        wr(A_DATA, 32'h12345678);
        rd(A_STATUS, s);
        chk(s[1] == 1'b1, "R6", "overflow on full", int'(s[1]), 1);
        chk(s[15:8] == 8'd16, "R6", "level after full write", int'(s[15:8]), 16);
        wr(A_STATUS, 32'd2);
        send_frame(64, 8'h05, 1, "R6 full");
    endtask

    task automatic t_reject();
        logic [31:0] s;
        wr(A_CHSEL, 32'd0);
        wr(A_LEN, 32'd0);
        wr(A_CTRL, 32'd1);
        rd(A_STATUS, s);
        chk(s[0] == 1'b0 && tx_valid == 1'b0, "R8", "zero length start", int'(s[0]), 0);
        load_words(1, 8'h60);
        wr(A_LEN, 32'd5);
        wr(A_CTRL, 32'd1);
        rd(A_STATUS, s);
        chk(s[0] == 1'b0 && tx_valid == 1'b0, "R8", "length beyond words", int'(s[0]), 0);
        wr(A_MODE, 32'd1);
        wr(A_LEN, 32'd4);
        wr(A_CTRL, 32'd1);
        rd(A_STATUS, s);
        chk(s[0] == 1'b0 && tx_valid == 1'b0, "R8", "start in feed mode 1", int'(s[0]), 0);
        wr(A_DATA, 32'hCAFEF00D);
        rd(A_STATUS, s);
        chk(s[15:8] == 8'd1, "R9", "feed mode 1 write level", int'(s[15:8]), 1);
        chk(s[1] == 1'b0, "R9", "feed mode 1 write flag", int'(s[1]), 0);
        wr(A_MODE, 32'd0);
        send_frame(4, 8'h60, 0, "R8 drain");
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(0, 2, 7, 8'h10, 0, "R3 pad");
        t_frame(0, 2, 8, 8'h40, 1, "R2 stall");
        t_frame(1, 1, 1, 8'h77, 0, "R3 single");
        t_frame(0, 3, 5, 8'hA0, 0, "R10 leftover");
        t_channels();
        t_busy_write();
        t_full();
        t_reject();
        done_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule